// File: doc/BRIEF.md
# Shader Program Sequencer with Shared Call/Address Stack

This block decides which instruction a small shader processor runs next. Each cycle in which `instr_valid` is high, it takes the already-decoded control fields of the instruction at `ip`. These are the vector and scalar opcodes, an 8-bit jump target, the end-of-program flag and the six-bit register numbers. It also takes the predicate result for that instruction and the current four-component address register. From these it updates the instruction pointer. Instructions run in sequence unless a predicated jump, call or return redirects them. The block also handles push and pop of the address register.

Return addresses and saved address registers share one last-in, first-out stack. The vector and scalar slots can both request a stack operation in the same instruction. Identical requests merge into one operation, and differing requests cancel each other. Execution stops with `abort` on a stack overflow or underflow, or when an instruction carries an illegal register number. It stops with `done` after the instruction that has the end flag. Both conditions persist until a `start` pulse.

Top module: `prog_sequencer`

## Requirements
- R1: After reset, and on the cycle after a `start` pulse, `ip` is 0, `done` and `abort` are 0, and the stack is empty. An instruction offered in the same cycle as `start` is not executed.
- R2: An executed instruction that neither redirects nor ends the program sets `ip` to `ip+1`, modulo 256 (255 wraps to 0).
- R3: An executed instruction with `last` high sets `done` and leaves `ip` on that instruction. `done` then stays high and `ip` stays unchanged until `start`.
- R4: Scalar opcode 9 (jump) with `pred_pass` high sets `ip` to `target`. With `pred_pass` low it behaves as R2.
- R5: Scalar opcode 11 (call) with `pred_pass` high pushes `ip+1` and sets `ip` to `target`. Scalar opcode 12 (return) with `pred_pass` high pops an entry and sets `ip` to its low 8 bits. With `pred_pass` low, neither touches the stack.
- R6: Vector opcode 26 or scalar opcode 19 pushes `areg_in`. Vector opcode 27 or scalar opcode 20 pops the top entry. A pop of the address register drives `areg_out` with the popped value and pulses `areg_out_valid` for one cycle. Pops come out in last-in, first-out order.
- R7: When the vector and scalar slots request the same address-register push (26 with 19), or the same pop (27 with 20), exactly one push or pop is performed.
- R8: When both slots request stack operations that differ, no stack operation is performed, no call or return redirect occurs, and `ip` advances as in R2.
- R9: A push to a full stack, or a pop from an empty one, raises `abort`. `ip` and the stack are then left unchanged.
- R10: Any of `src_a`, `src_b` or `src_c` in 32..63, or `dst_vec` or `dst_sca` in 32..62, raises `abort` whatever the opcodes are. Destination 63 is legal.
- R11: While `abort` is high, further instructions are ignored: `ip` stays frozen and `abort` stays high until `start`.
- R12: Return addresses and address-register saves live on one stack. A return issued right after an address-register push consumes that saved value as its jump address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Restart pulse: clears pointer, stack and status |
| instr_valid | input | 1 | The fields below describe the instruction at `ip` and are to be executed |
| vec_op | input | 5 | Vector slot opcode |
| sca_op | input | 5 | Scalar slot opcode |
| target | input | IADDR_W | Jump or call destination |
| last | input | 1 | End-of-program flag of this instruction |
| src_a | input | 6 | First source register number |
| src_b | input | 6 | Second source register number |
| src_c | input | 6 | Third source register number |
| dst_vec | input | 6 | Vector destination register number |
| dst_sca | input | 6 | Scalar destination register number |
| pred_pass | input | 1 | Predicate test result for this instruction |
| areg_in | input | 4*AREG_W | Current address register, four packed components |
| ip | output | IADDR_W | Instruction pointer |
| areg_out | output | 4*AREG_W | Address register value from the latest pop |
| areg_out_valid | output | 1 | One-cycle pulse when `areg_out` was just popped |
| done | output | 1 | Program has ended |
| abort | output | 1 | Program was aborted |

## Verification
The bench builds the sequencer with a 4-entry stack and 6-bit address components, so overflow is reached after four pushes. It keeps the 8-bit pointer, which lets it sweep every pointer value, every jump target and the 255-to-0 wrap. It also covers the full matrix of vector-slot against scalar-slot stack requests and measures the resulting stack depth by popping until underflow. The register-field check is swept over the boundary values 31, 32, 47, 62 and 63 on each of the five fields.

// File: rtl/seq_pkg.sv
`timescale 1ns/1ps
package seq_pkg;

  localparam int REG_W = 6;

  localparam logic [4:0] VOP_ARPUSH = 5'd26;
  localparam logic [4:0] VOP_ARPOP  = 5'd27;
  localparam logic [4:0] SOP_JUMP   = 5'd9;
  localparam logic [4:0] SOP_CALL   = 5'd11;
  localparam logic [4:0] SOP_RETURN = 5'd12;
  localparam logic [4:0] SOP_ARPUSH = 5'd19;
  localparam logic [4:0] SOP_ARPOP  = 5'd20;

  typedef enum logic [2:0] {
    SK_NONE     = 3'd0,
    SK_PUSH_AR  = 3'd1,
    SK_POP_AR   = 3'd2,
    SK_PUSH_RET = 3'd3,
    SK_POP_RET  = 3'd4
  } stk_kind_e;

  // source numbers above the register file are illegal
  function automatic logic src_illegal(input logic [REG_W-1:0] r);
    return r[REG_W-1];
  endfunction

  // destination numbers above the register file are illegal, except the all-ones dummy
  function automatic logic dst_illegal(input logic [REG_W-1:0] r);
    return r[REG_W-1] && (r != {REG_W{1'b1}});
  endfunction

  // merge the two slot requests: equal merges, different cancels
  function automatic stk_kind_e merge_kind(input stk_kind_e v, input stk_kind_e s);
    if (v == SK_NONE) return s;
    if (s == SK_NONE) return v;
    if (v == s)       return v;
    return SK_NONE;
  endfunction

endpackage

// File: rtl/seq_field_check.sv
`timescale 1ns/1ps
module seq_field_check
  import seq_pkg::*;
(
  input  logic [2:0][REG_W-1:0] srcs,
  input  logic [1:0][REG_W-1:0] dsts,
  output logic                  bad
);

  logic [2:0] src_bad;
  logic [1:0] dst_bad;

  for (genvar g = 0; g < 3; g++) begin : g_src
    assign src_bad[g] = src_illegal(srcs[g]);
  end

  for (genvar g = 0; g < 2; g++) begin : g_dst
    assign dst_bad[g] = dst_illegal(dsts[g]);
  end

  assign bad = (|src_bad) | (|dst_bad);

endmodule

// File: rtl/seq_stack_arbiter.sv
`timescale 1ns/1ps
module seq_stack_arbiter
  import seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] vec_op,
  input  logic [4:0] sca_op,
  input  logic       pred_pass,
  output logic       push,
  output logic       pop,
  output logic       ret_push,
  output logic       ret_pop,
  output logic       ar_pop,
  output logic       jump_taken,
  output logic       conflict
);

  stk_kind_e vk, sk, kind;

  always_comb begin
    unique case (vec_op)
      VOP_ARPUSH: vk = SK_PUSH_AR;
      VOP_ARPOP:  vk = SK_POP_AR;
      default:    vk = SK_NONE;
    endcase
  end

  always_comb begin
    sk = SK_NONE;
    if (sca_op == SOP_ARPUSH)                   sk = SK_PUSH_AR;
    else if (sca_op == SOP_ARPOP)               sk = SK_POP_AR;
    else if (sca_op == SOP_CALL   && pred_pass) sk = SK_PUSH_RET;
    else if (sca_op == SOP_RETURN && pred_pass) sk = SK_POP_RET;
  end

  assign kind       = merge_kind(vk, sk);
  assign conflict   = (vk != SK_NONE) && (sk != SK_NONE) && (vk != sk);
  assign push       = (kind == SK_PUSH_AR) || (kind == SK_PUSH_RET);
  assign pop        = (kind == SK_POP_AR)  || (kind == SK_POP_RET);
  assign ret_push   = (kind == SK_PUSH_RET);
  assign ret_pop    = (kind == SK_POP_RET);
  assign ar_pop     = (kind == SK_POP_AR);
  assign jump_taken = (sca_op == SOP_JUMP) && pred_pass;

  AST_SAME_PUSH_MERGES: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_op == VOP_ARPUSH && sca_op == SOP_ARPUSH) |-> (push && !pop)); // R7
  AST_SAME_POP_MERGES: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_op == VOP_ARPOP && sca_op == SOP_ARPOP) |-> (pop && !push)); // R7
  AST_MIXED_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_op == VOP_ARPUSH && sca_op == SOP_ARPOP) |-> (!push && !pop)); // R8

endmodule

// File: rtl/seq_stack.sv
`timescale 1ns/1ps
module seq_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         push_en,
  input  logic         pop_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);

  localparam int SP_W = $clog2(DEPTH + 1);

  logic [SP_W-1:0]    sp_q;
  logic [SP_W-1:0]    top_idx;
  logic [DEPTH*W-1:0] flat;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [W-1:0] ent_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              ent_q <= '0;
      else if (push_en && sp_q == SP_W'(g))    ent_q <= wdata;
    end
    assign flat[g*W +: W] = ent_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sp_q <= '0;
    else if (clear)    sp_q <= '0;
    else if (push_en)  sp_q <= sp_q + 1'b1;
    else if (pop_en)   sp_q <= sp_q - 1'b1;
  end

  assign empty   = (sp_q == '0);
  assign full    = (sp_q == SP_W'(DEPTH));
  assign top_idx = empty ? '0 : sp_q - 1'b1;
  assign rdata   = flat[top_idx*W +: W];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> !full); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |-> !empty); // R9
  AST_SP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q <= SP_W'(DEPTH)); // R9
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && !clear) |=> (sp_q == $past(sp_q) + 1'b1)); // R6

endmodule

// File: rtl/prog_sequencer.sv
`timescale 1ns/1ps
module prog_sequencer
  import seq_pkg::*;
#(
  parameter int IADDR_W     = 8,
  parameter int STACK_DEPTH = 8,
  parameter int AREG_W      = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  instr_valid,
  input  logic [4:0]            vec_op,
  input  logic [4:0]            sca_op,
  input  logic [IADDR_W-1:0]    target,
  input  logic                  last,
  input  logic [5:0]            src_a,
  input  logic [5:0]            src_b,
  input  logic [5:0]            src_c,
  input  logic [5:0]            dst_vec,
  input  logic [5:0]            dst_sca,
  input  logic                  pred_pass,
  input  logic [4*AREG_W-1:0]   areg_in,
  output logic [IADDR_W-1:0]    ip,
  output logic [4*AREG_W-1:0]   areg_out,
  output logic                  areg_out_valid,
  output logic                  done,
  output logic                  abort
);

  localparam int AR_W  = 4 * AREG_W;
  localparam int ENT_W = (IADDR_W > AR_W) ? IADDR_W : AR_W;

  logic [IADDR_W-1:0] ip_q, ip_plus, next_ip;
  logic               done_q, abort_q, pop_v_q;
  logic [AR_W-1:0]    pop_d_q;

  logic field_bad;
  logic stk_push, stk_pop, ret_push, ret_pop, ar_pop, jump_taken, conflict;
  logic stk_full, stk_empty;
  logic [ENT_W-1:0] stk_rdata, stk_wdata;
  logic step, stack_err, fault, exec, push_en, pop_en;

  seq_field_check u_fields (
    .srcs ({src_c, src_b, src_a}),
    .dsts ({dst_sca, dst_vec}),
    .bad  (field_bad)
  );

  seq_stack_arbiter u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .vec_op     (vec_op),
    .sca_op     (sca_op),
    .pred_pass  (pred_pass),
    .push       (stk_push),
    .pop        (stk_pop),
    .ret_push   (ret_push),
    .ret_pop    (ret_pop),
    .ar_pop     (ar_pop),
    .jump_taken (jump_taken),
    .conflict   (conflict)
  );

  // an instruction is only looked at while running and not restarting
  assign step      = instr_valid && !done_q && !abort_q && !start;
  assign stack_err = (stk_push && stk_full) || (stk_pop && stk_empty);
  assign fault     = step && (field_bad || stack_err);
  assign exec      = step && !fault;
  assign push_en   = exec && stk_push;
  assign pop_en    = exec && stk_pop;

  assign ip_plus   = ip_q + 1'b1;
  assign stk_wdata = ret_push ? ENT_W'(ip_plus) : ENT_W'(areg_in);

  always_comb begin
    if (jump_taken)     next_ip = target;
    else if (ret_push)  next_ip = target;
    else if (ret_pop)   next_ip = stk_rdata[IADDR_W-1:0];
    else                next_ip = ip_plus;
  end

  seq_stack #(
    .DEPTH (STACK_DEPTH),
    .W     (ENT_W)
  ) u_stack (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start),
    .push_en (push_en),
    .pop_en  (pop_en),
    .wdata   (stk_wdata),
    .rdata   (stk_rdata),
    .full    (stk_full),
    .empty   (stk_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ip_q    <= '0;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      pop_v_q <= 1'b0;
      pop_d_q <= '0;
    end else if (start) begin
      ip_q    <= '0;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      pop_v_q <= 1'b0;
    end else begin
      pop_v_q <= 1'b0;
      if (fault) begin
        abort_q <= 1'b1;
      end else if (exec) begin
        if (ar_pop) begin
          pop_v_q <= 1'b1;
          pop_d_q <= stk_rdata[AR_W-1:0];
        end
        if (last) done_q <= 1'b1;
        else      ip_q   <= next_ip;
      end
    end
  end

  assign ip             = ip_q;
  assign done           = done_q;
  assign abort          = abort_q;
  assign areg_out       = pop_d_q;
  assign areg_out_valid = pop_v_q;

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (ip == '0 && !done && !abort)); // R1
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(ip))); // R3
  AST_ABORT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !start) |=> (abort && $stable(ip))); // R11
  AST_BAD_FIELD_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && field_bad) |=> abort); // R10
  AST_JUMP_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && jump_taken && !last) |=> (ip == $past(target))); // R4
  AST_STACK_ERR_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && stack_err) |=> (abort && $stable(ip))); // R9
  AST_CONFLICT_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && conflict && !jump_taken && !last) |=> (ip == $past(ip) + 1'b1)); // R8

endmodule

// File: tb/prog_sequencer_tb.sv
`timescale 1ns/1ps
module prog_sequencer_tb;

  localparam int AW = 6;
  localparam int AR = 4 * AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic instr_valid = 1'b0;
  logic [4:0] vec_op = '0, sca_op = '0;
  logic [7:0] target = '0;
  logic last = 1'b0, pred_pass = 1'b0;
  logic [5:0] src_a = '0, src_b = '0, src_c = '0, dst_vec = '0, dst_sca = '0;
  logic [AR-1:0] areg_in = '0;
  logic [7:0] ip;
  logic [AR-1:0] areg_out;
  logic areg_out_valid, done, abort;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  prog_sequencer #(.IADDR_W(8), .STACK_DEPTH(4), .AREG_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr_valid(instr_valid),
    .vec_op(vec_op), .sca_op(sca_op), .target(target), .last(last),
    .src_a(src_a), .src_b(src_b), .src_c(src_c), .dst_vec(dst_vec), .dst_sca(dst_sca),
    .pred_pass(pred_pass), .areg_in(areg_in), .ip(ip), .areg_out(areg_out),
    .areg_out_valid(areg_out_valid), .done(done), .abort(abort)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [4:0] v, input logic [4:0] s, input logic [7:0] t,
                       input logic l, input logic p, input logic [AR-1:0] a);
    @(negedge clk);
    vec_op = v; sca_op = s; target = t; last = l; pred_pass = p; areg_in = a;
    instr_valid = 1'b1;
    @(posedge clk); #1;
    instr_valid = 1'b0; vec_op = '0; sca_op = '0; last = 1'b0; pred_pass = 1'b0;
  endtask

  task automatic restart();
    @(negedge clk); start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
  endtask

  function automatic logic [4:0] sop_of(input int k);
    case (k)
      1: return 5'd19;
      2: return 5'd20;
      3: return 5'd11;
      4: return 5'd12;
      default: return 5'd0;
    endcase
  endfunction

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset ip", ip, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset abort", abort, 0);

    // R2: every pointer value and the wrap
    for (int i = 0; i < 260; i++) begin
      issue(5'd0, 5'd0, 8'h00, 1'b0, 1'b1, '0);
      chk("R2 advance", ip, (i + 1) % 256);
    end

    // R4: every target, taken then not taken
    for (int t = 0; t < 256; t++) begin
      issue(5'd0, 5'd9, 8'(t), 1'b0, 1'b1, '0);
      chk("R4 jump taken", ip, t);
      issue(5'd0, 5'd9, 8'(t + 77), 1'b0, 1'b0, '0);
      chk("R4 jump not taken", ip, (t + 1) % 256);
    end

    // R1: start clears, same-cycle instruction ignored
    @(negedge clk);
    start = 1'b1; instr_valid = 1'b1; sca_op = 5'd9; pred_pass = 1'b1; target = 8'h55;
    @(posedge clk); #1;
    start = 1'b0; instr_valid = 1'b0; sca_op = '0; pred_pass = 1'b0;
    chk("R1 start ip", ip, 0);
    chk("R1 start abort", abort, 0);

    // R5: call and return
    for (int i = 0; i < 5; i++) issue(5'd0, 5'd0, 8'h00, 1'b0, 1'b0, '0);
    issue(5'd0, 5'd11, 8'h80, 1'b0, 1'b1, '0);
    chk("R5 call target", ip, 8'h80);
    issue(5'd0, 5'd11, 8'h20, 1'b0, 1'b0, '0);
    chk("R5 call not taken", ip, 8'h81);
    issue(5'd0, 5'd12, 8'h00, 1'b0, 1'b0, '0);
    chk("R5 return not taken", ip, 8'h82);
    issue(5'd0, 5'd12, 8'h00, 1'b0, 1'b1, '0);
    chk("R5 return address", ip, 8'h06);
    chk("R5 return no abort", abort, 0);
    issue(5'd0, 5'd12, 8'h00, 1'b0, 1'b1, '0);
    chk("R9 underflow abort", abort, 1);
    chk("R9 underflow ip held", ip, 8'h06);

    // R11: frozen while aborted
    issue(5'd0, 5'd9, 8'h44, 1'b0, 1'b1, '0);
    chk("R11 ip frozen", ip, 8'h06);
    chk("R11 abort sticky", abort, 1);
    restart();
    chk("R1 start after abort", abort, 0);

    // R6: LIFO of address registers, both slots
    issue(5'd0, 5'd19, 8'h00, 1'b0, 1'b0, 24'h111111);
    issue(5'd26, 5'd0, 8'h00, 1'b0, 1'b0, 24'h222222);
    issue(5'd0, 5'd19, 8'h00, 1'b0, 1'b0, 24'h333333);
    chk("R6 push no pulse", areg_out_valid, 0);
    issue(5'd0, 5'd20, 8'h00, 1'b0, 1'b0, '0);
    chk("R6 pop pulse", areg_out_valid, 1);
    chk("R6 pop third", areg_out, 24'h333333);
    issue(5'd27, 5'd0, 8'h00, 1'b0, 1'b0, '0);
    chk("R6 pop second", areg_out, 24'h222222);
    issue(5'd0, 5'd20, 8'h00, 1'b0, 1'b0, '0);
    chk("R6 pop first", areg_out, 24'h111111);
    issue(5'd0, 5'd0, 8'h00, 1'b0, 1'b0, '0);
    chk("R6 pulse ends", areg_out_valid, 0);
    chk("R6 ip", ip, 7);

    // R7/R8: slot request matrix, then depth measured by draining
    for (int vk = 0; vk < 3; vk++) begin
      for (int sk = 0; sk < 5; sk++) begin
        int comb, depth, expip, cnt;
        comb = (vk == 0) ? sk : (sk == 0) ? vk : (vk == sk) ? vk : 0;
        depth = (comb == 1 || comb == 3) ? 2 : (comb == 2 || comb == 4) ? 0 : 1;
        expip = (comb == 3) ? 8'h40 : (comb == 4) ? 8'h33 : 2;
        restart();
        issue(5'd26, 5'd0, 8'h00, 1'b0, 1'b0, 24'hABC033);
        issue((vk == 1) ? 5'd26 : (vk == 2) ? 5'd27 : 5'd0, sop_of(sk), 8'h40,
              1'b0, 1'b1, 24'h123456);
        chk("R8 matrix ip", ip, expip);
        chk("R8 matrix abort", abort, 0);
        chk("R7 matrix pop pulse", areg_out_valid, (comb == 2) ? 1 : 0);
        if (comb == 2) chk("R7 matrix pop data", areg_out, 24'hABC033);
        cnt = 0;
        while (!abort && cnt < 6) begin
          issue(5'd0, 5'd20, 8'h00, 1'b0, 1'b0, '0);
          if (!abort) cnt++;
        end
        chk("R7 matrix depth", cnt, depth);
      end
    end

    // R9: overflow
    restart();
    for (int i = 0; i < 4; i++) issue(5'd0, 5'd19, 8'h00, 1'b0, 1'b0, 24'(i));
    chk("R9 four pushes ok", abort, 0);
    issue(5'd26, 5'd0, 8'h00, 1'b0, 1'b0, '0);
    chk("R9 overflow abort", abort, 1);
    chk("R9 overflow ip held", ip, 4);

    // R10: register field boundaries
    for (int f = 0; f < 5; f++) begin
      for (int k = 0; k < 5; k++) begin
        logic [5:0] v;
        logic bad;
        v = (k == 0) ? 6'd31 : (k == 1) ? 6'd32 : (k == 2) ? 6'd47 : (k == 3) ? 6'd62 : 6'd63;
        bad = (f < 3) ? (v >= 32) : (v >= 32 && v != 63);
        restart();
        @(negedge clk);
        case (f)
          0: src_a = v;
          1: src_b = v;
          2: src_c = v;
          3: dst_vec = v;
          default: dst_sca = v;
        endcase
        issue(5'd0, 5'd0, 8'h00, 1'b0, 1'b0, '0);
        src_a = '0; src_b = '0; src_c = '0; dst_vec = '0; dst_sca = '0;
        chk("R10 field abort", abort, bad);
        chk("R10 field ip", ip, bad ? 0 : 1);
      end
    end

    // R3: end of program
    restart();
    issue(5'd0, 5'd0, 8'h00, 1'b0, 1'b0, '0);
    issue(5'd0, 5'd0, 8'h00, 1'b0, 1'b0, '0);
    issue(5'd0, 5'd9, 8'h70, 1'b1, 1'b1, '0);
    chk("R3 done", done, 1);
    chk("R3 ip stays", ip, 2);
    issue(5'd0, 5'd9, 8'h30, 1'b0, 1'b1, '0);
    chk("R3 ignored after done", ip, 2);
    chk("R3 done sticky", done, 1);
    restart();
    chk("R1 start clears done", done, 0);

    // R12: shared stack
    issue(5'd0, 5'd11, 8'h10, 1'b0, 1'b1, '0);
    issue(5'd0, 5'd19, 8'h00, 1'b0, 1'b0, 24'h0000A5);
    issue(5'd0, 5'd12, 8'h00, 1'b0, 1'b1, '0);
    chk("R12 return uses saved value", ip, 8'hA5);
    issue(5'd0, 5'd12, 8'h00, 1'b0, 1'b1, '0);
    chk("R12 return address beneath", ip, 8'h01);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule